// File: doc/BRIEF.md
# Power-Good Reset and Fault Supervisor

This block supervises two switching supply rails: a low rail (3.3 V, index 0) and a high rail (5 V, index 1). It watches per-rail status flags from external comparators and produces a delayed, active-low system reset. After the monitored rails come into regulation, the reset stays asserted for a fixed number of switching-oscillator ticks. The tick is a single-cycle strobe in the `clk` domain. All inputs and outputs are plain level signals. There is no stream interface, so no handshake or back-pressure rules apply.

The block also latches two kinds of fault. An undervoltage fault is checked on a rail only after that rail has been enabled for a blanking interval. When it fires, it shuts both rails off. An overvoltage fault is checked at all times. Both faults request that both low-side switches be held on. Once set, a fault stays set until the bench of outside logic produces an edge on either the shutdown input or the run input, or until a power-on reset. Both of these inputs are asynchronous and are synchronized inside the block. The comparators that produce the flags are outside this block.

Top module: `pgood_supervisor`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it is released, `sys_reset_n` = 0, `fault_off` = 0 and `lowside_force` = 2'b00.
- R2: `sys_reset_n` rises on the clock edge that samples the RST_TICKS-th `osc_tick` seen while the monitored rails were continuously in regulation. The edge at which regulation begins counts as the first such sample.
- R3: With `indep_mode` = 1 only `rail_ok[0]` is monitored and `rail_ok[1]` is ignored. With `indep_mode` = 0 both bits must be 1.
- R4: If the monitored rails leave regulation while the count is running, the count restarts from zero and `sys_reset_n` stays 0.
- R5: Once `sys_reset_n` is 1, it goes to 0 one cycle after any monitored `rail_ok` bit is sampled 0.
- R6: Undervoltage checking on rail r is armed only after BLANK_TICKS ticks have been sampled with `rail_en[r]` = 1. Dropping `rail_en[r]` disarms the rail and restarts its count. A `rail_uv[r]` on a rail that is not armed has no effect.
- R7: When an armed rail reports `rail_uv` = 1, on the next cycle `fault_off` = 1 and `lowside_force` = 2'b11.
- R8: Any `rail_ov` bit sampled 1 makes `lowside_force` = 2'b11 on the next cycle, without setting `fault_off`.
- R9: Both latches hold until an edge of `stop_n` or `run_req` reaches the end of the SYNC_STAGES-flop synchronizer. They clear on the following clock edge, which is SYNC_STAGES+1 edges after the input changes. A steady level has no effect. A fault flag sampled on the clearing edge wins over the clear.
- R10: A power-on reset (`rst_n` low) clears both latches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| osc_tick | input | 1 | One-cycle strobe per switching-oscillator period |
| rail_en | input | 2 | Rail enables, bit 0 = 3.3 V, bit 1 = 5 V |
| rail_ok | input | 2 | Rail in regulation |
| rail_uv | input | 2 | Rail below 70 % of nominal |
| rail_ov | input | 2 | Rail above 107 % of nominal |
| indep_mode | input | 1 | 1 = rails controlled independently; only 3.3 V gates the reset |
| stop_n | input | 1 | Asynchronous shutdown control; an edge clears faults |
| run_req | input | 1 | Asynchronous master run control; an edge clears faults |
| sys_reset_n | output | 1 | Delayed active-low system reset |
| fault_off | output | 1 | Latched undervoltage shutdown of both rails |
| lowside_force | output | 2 | Per-rail request to hold the low-side switch on |

## Verification
The reset timer is driven by a steady climb into regulation, by a dropout partway through the count, and by a dropout after release. Together these separate a counter that restarts from one that only pauses, and a registered release from one that lags. Mode switching with the high rail held out of regulation shows whether that rail is really ignored. The fault latches see an undervoltage flag before and after arming, and again after the rail enable is cycled, which exposes arming that comes early or is never cleared. Held control levels are compared with real edges on each control input, which separates edge clearing from level clearing.

// File: rtl/pgs_pkg.sv
package pgs_pkg;
  localparam int RAILS   = 2;
  localparam int RAIL_LO = 0;  // 3.3 V rail, always monitored
  localparam int RAIL_HI = 1;  // 5 V rail, ignored in independent mode

  typedef struct packed {
    logic uv;
    logic ov;
  } fault_t;
endpackage

// File: rtl/pgs_sync_edge.sv
module pgs_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic toggle
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
      last  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], async_in};
      last  <= chain[STAGES-1];
    end
  end

  assign toggle = chain[STAGES-1] ^ last;
endmodule

// File: rtl/pgs_arm_timer.sv
module pgs_arm_timer #(
  parameter int BLANK_TICKS = 6144
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic en,
  output logic armed
);
  localparam int CW = $clog2(BLANK_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(BLANK_TICKS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (!en) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (tick && !armed) begin
      if (cnt == LAST) armed <= 1'b1;
      else             cnt   <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pgs_reset_timer.sv
module pgs_reset_timer #(
  parameter int RST_TICKS = 32000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic good,
  output logic released
);
  localparam int CW = $clog2(RST_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(RST_TICKS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      released <= 1'b0;
    end else if (!good) begin
      cnt      <= '0;
      released <= 1'b0;
    end else if (tick && !released) begin
      if (cnt == LAST) released <= 1'b1;
      else             cnt      <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pgs_fault_latch.sv
module pgs_fault_latch
  import pgs_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  fault_t set_in,
  input  logic   clr,
  output fault_t state
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= '0;
    end else begin
      state.uv <= set_in.uv | (state.uv & ~clr);
      state.ov <= set_in.ov | (state.ov & ~clr);
    end
  end
endmodule

// File: rtl/pgood_supervisor.sv
module pgood_supervisor
  import pgs_pkg::*;
#(
  parameter int RST_TICKS   = 32000,
  parameter int BLANK_TICKS = 6144,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_tick,
  input  logic [RAILS-1:0] rail_en,
  input  logic [RAILS-1:0] rail_ok,
  input  logic [RAILS-1:0] rail_uv,
  input  logic [RAILS-1:0] rail_ov,
  input  logic             indep_mode,
  input  logic             stop_n,
  input  logic             run_req,
  output logic             sys_reset_n,
  output logic             fault_off,
  output logic [RAILS-1:0] lowside_force
);
  logic [RAILS-1:0] armed;
  logic             stop_tgl, run_tgl, clr_pulse;
  logic             mon_good;
  fault_t           fset, fstate;

  for (genvar r = 0; r < RAILS; r++) begin : g_arm
    pgs_arm_timer #(.BLANK_TICKS(BLANK_TICKS)) u_arm (
      .clk(clk), .rst_n(rst_n), .tick(osc_tick),
      .en(rail_en[r]), .armed(armed[r])
    );
  end

  pgs_sync_edge #(.STAGES(SYNC_STAGES)) u_stop_sync (
    .clk(clk), .rst_n(rst_n), .async_in(stop_n), .toggle(stop_tgl)
  );
  pgs_sync_edge #(.STAGES(SYNC_STAGES)) u_run_sync (
    .clk(clk), .rst_n(rst_n), .async_in(run_req), .toggle(run_tgl)
  );
  assign clr_pulse = stop_tgl | run_tgl;

  always_comb begin
    fset.uv = |(armed & rail_uv);
    fset.ov = |rail_ov;
  end

  pgs_fault_latch u_latch (
    .clk(clk), .rst_n(rst_n), .set_in(fset), .clr(clr_pulse), .state(fstate)
  );

  assign mon_good = indep_mode ? rail_ok[RAIL_LO] : (&rail_ok);

  pgs_reset_timer #(.RST_TICKS(RST_TICKS)) u_rst (
    .clk(clk), .rst_n(rst_n), .tick(osc_tick), .good(mon_good),
    .released(sys_reset_n)
  );

  assign fault_off     = fstate.uv;
  assign lowside_force = {RAILS{fstate.uv | fstate.ov}};
endmodule

// File: rtl/pgood_supervisor_chk.sv
module pgood_supervisor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] rail_en,
  input logic [1:0] rail_ok,
  input logic [1:0] rail_uv,
  input logic [1:0] rail_ov,
  input logic       indep_mode,
  input logic       clr_pulse,
  input logic       sys_reset_n,
  input logic       fault_off,
  input logic [1:0] lowside_force
);
  logic mon_ok;
  assign mon_ok = indep_mode ? rail_ok[0] : (rail_ok[0] & rail_ok[1]);

  // R4
  drop_holds_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mon_ok |=> !sys_reset_n);
  // R2
  release_needs_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_reset_n) |-> $past(mon_ok));
  // R7
  uv_forces_lowside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_off |-> (lowside_force == 2'b11));
  // R6
  uv_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_off) |-> $past(|(rail_uv & rail_en)));
  // R8
  ov_forces_lowside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|rail_ov) |=> (lowside_force == 2'b11));
  // R9
  clear_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_off) |-> $past(clr_pulse));
endmodule

bind pgood_supervisor pgood_supervisor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rail_en(rail_en), .rail_ok(rail_ok),
  .rail_uv(rail_uv), .rail_ov(rail_ov), .indep_mode(indep_mode),
  .clr_pulse(clr_pulse), .sys_reset_n(sys_reset_n), .fault_off(fault_off),
  .lowside_force(lowside_force)
);

// File: tb/tb_pgood_supervisor.sv
module tb_pgood_supervisor;
  localparam int RT = 20, BT = 12, SS = 2;

  logic clk = 1'b0, rst_n = 1'b0, osc_tick = 1'b0;
  logic [1:0] rail_en = '0, rail_ok = '0, rail_uv = '0, rail_ov = '0;
  logic indep_mode = 1'b0, stop_n = 1'b1, run_req = 1'b1;
  logic sys_reset_n, fault_off;
  logic [1:0] lowside_force;

  int checks = 0, errors = 0, cyc = 0;
  string phase = "R1";
  bit done = 0;

  pgood_supervisor #(.RST_TICKS(RT), .BLANK_TICKS(BT), .SYNC_STAGES(SS)) dut (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .rail_en(rail_en),
    .rail_ok(rail_ok), .rail_uv(rail_uv), .rail_ov(rail_ov),
    .indep_mode(indep_mode), .stop_n(stop_n), .run_req(run_req),
    .sys_reset_n(sys_reset_n), .fault_off(fault_off), .lowside_force(lowside_force)
  );

  always #2 clk = ~clk;

  // behavioural reference model
  int  seen_rst, seen_arm[2];
  bit  m_rel, m_uv, m_ov, m_arm[2];
  bit  stop_q[$], run_q[$];
  bit  stop_old, run_old;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_rst = 0; m_rel = 0; m_uv = 0; m_ov = 0;
      foreach (m_arm[r]) begin m_arm[r] = 0; seen_arm[r] = 0; end
      stop_q = {}; run_q = {};
      for (int i = 0; i < SS; i++) begin stop_q.push_back(0); run_q.push_back(0); end
      stop_old = 0; run_old = 0;
    end else begin
      bit clr, uvs, ovs, good;
      clr = (stop_q[SS-1] != stop_old) || (run_q[SS-1] != run_old);
      uvs = (m_arm[0] && rail_uv[0]) || (m_arm[1] && rail_uv[1]);
      ovs = rail_ov != 2'b00;
      m_uv = uvs || (m_uv && !clr);
      m_ov = ovs || (m_ov && !clr);
      for (int r = 0; r < 2; r++) begin
        if (!rail_en[r]) begin seen_arm[r] = 0; m_arm[r] = 0; end
        else if (osc_tick && !m_arm[r]) begin
          seen_arm[r]++;
          if (seen_arm[r] == BT) m_arm[r] = 1;
        end
      end
      good = indep_mode ? rail_ok[0] : (rail_ok == 2'b11);
      if (!good) begin seen_rst = 0; m_rel = 0; end
      else if (osc_tick && !m_rel) begin
        seen_rst++;
        if (seen_rst == RT) m_rel = 1;
      end
      stop_old = stop_q[SS-1]; run_old = run_q[SS-1];
      void'(stop_q.pop_back()); stop_q.push_front(stop_n);
      void'(run_q.pop_back());  run_q.push_front(run_req);
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (!done) begin
    cyc++;
    chk(phase, "sys_reset_n", int'(sys_reset_n), int'(m_rel));
    chk(phase, "fault_off", int'(fault_off), int'(m_uv));
    chk(phase, "lowside_force", int'(lowside_force), (m_uv || m_ov) ? 3 : 0);
    if (cyc > 5000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected<=5000", cyc);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  always @(posedge clk) begin #1; osc_tick <= ~osc_tick; end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    chk("R1", "reset state", {sys_reset_n, fault_off, lowside_force}, 0);
    phase = "R2"; rail_ok = 2'b11; step(60);
    chk("R2", "released", sys_reset_n, 1);
    phase = "R5"; rail_ok = 2'b01; step(2);
    chk("R5", "dropped", sys_reset_n, 0);
    phase = "R4"; rail_ok = 2'b11; step(20);
    rail_ok = 2'b10; step(1);
    rail_ok = 2'b11; step(30);
    chk("R4", "restarted count", sys_reset_n, 0);
    step(20);
    chk("R4", "released late", sys_reset_n, 1);
    phase = "R3"; indep_mode = 1'b1; rail_ok = 2'b01; step(3);
    chk("R3", "high rail ignored", sys_reset_n, 1);
    rail_ok = 2'b00; step(2);
    rail_ok = 2'b01; step(50);
    chk("R3", "release on low rail only", sys_reset_n, 1);
    indep_mode = 1'b0;
    phase = "R6"; rail_en = 2'b11; rail_uv = 2'b01; step(10);
    chk("R6", "uv before arming", fault_off, 0);
    phase = "R7"; step(30);
    chk("R7", "uv latched", fault_off, 1);
    chk("R7", "lowside forced", lowside_force, 3);
    phase = "R9"; rail_uv = 2'b00; step(10);
    chk("R9", "held on level", fault_off, 1);
    run_req = 1'b0; step(6);
    chk("R9", "cleared by run edge", fault_off, 0);
    run_req = 1'b1; step(6);
    phase = "R8"; rail_ov = 2'b10; step(1);
    rail_ov = 2'b00; step(3);
    chk("R8", "ov forces lowside", lowside_force, 3);
    chk("R8", "ov leaves fault_off", fault_off, 0);
    phase = "R9"; step(5);
    chk("R9", "ov held", lowside_force, 3);
    stop_n = 1'b0; step(6);
    chk("R9", "cleared by stop edge", lowside_force, 0);
    stop_n = 1'b1; step(6);
    phase = "R6"; rail_en = 2'b00; step(2);
    rail_en = 2'b11; rail_uv = 2'b10; step(10);
    chk("R6", "disarmed after enable drop", fault_off, 0);
    rail_uv = 2'b00;
    phase = "R10"; rail_ov = 2'b01; step(1);
    rail_ov = 2'b00; step(2);
    rst_n = 1'b0; step(2);
    chk("R10", "por clears", lowside_force, 0);
    rst_n = 1'b1; step(2);
    chk("R10", "after por", {fault_off, lowside_force}, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule